// File: doc/BRIEF.md
# Six-Source Vectored Interrupt Arbiter

This block decides which pending interrupt a small 8-bit CPU core should service next, and where the CPU should jump. Six sources feed it: two external event lines, two timer overflow lines, a serial port with separate receive and transmit flags that share one vector, and a power-fail warning. The event flags live in the peripherals. The arbiter only reads them, together with the enable and priority register contents and two strobes from the CPU. One strobe marks an instruction boundary. The other marks a return-from-interrupt.

When the CPU signals an instruction boundary, the arbiter picks the winning source among those that are enabled and allowed at the current nesting state. In the following cycle it pulses a request and holds the vector address. In that same cycle it pulses a clear line back to the peripheral that owns the flag. The serial source is the exception: it gets no clear, because software must find out whether a receive or a transmit event caused the call. Two in-service levels let a high-priority routine preempt a low-priority one. The power-fail warning is always high priority. It ignores the global enable and is gated only by its own enable bit.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, `irq_req` and every bit of `flag_clr` are 0, and no request appears until an instruction-boundary strobe finds an allowed pending source.
- R2: Vector addresses by source are 0x0003 for external 0, 0x000B for timer 0, 0x0013 for external 1, 0x001B for timer 1, 0x0023 for serial and 0x002B for power-fail.
- R3: A source other than power-fail is taken only when `en_reg[7]` (global enable) is 1. Power-fail is taken with `en_reg[7]` at 0, provided `pwr_en` is 1.
- R4: Per-source enables are `en_reg[0]` external 0, `en_reg[1]` timer 0, `en_reg[2]` external 1, `en_reg[3]` timer 1, `en_reg[4]` serial, and `pwr_en` for power-fail. A pending flag whose enable is 0 is never taken.
- R5: A source is taken only at a rising clock edge where `insn_done` is 1. `irq_req` is then 1 for exactly the next cycle, with `irq_vec` holding the vector.
- R6: `flag_clr` is indexed 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial, 5 power-fail. The bit of the taken source pulses in the request cycle. Bit 4 never pulses, so a serial flag that is left set is taken again after return.
- R7: Either `ser_rx_flag` or `ser_tx_flag` raises the serial vector.
- R8: Among allowed sources of the same level, the order is power-fail, external 0, timer 0, external 1, timer 1, serial.
- R9: `pri_reg[4:0]` (same bit order as R4) marks a source high priority when 1. Power-fail is always high. A high-level source wins over any low-level one.
- R10: While a low-level routine is in service, only high-level sources are taken. While a high-level routine is in service, nothing is taken.
- R11: A `reti` pulse ends the highest level in service: the high level if it is active, otherwise the low level.
- R12: A boundary strobe is ignored in a cycle where `reti` is 1 or `irq_req` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| main_flag | input | 4 | Event flags: ext0, tmr0, ext1, tmr1 (bit 0 to 3) |
| ser_rx_flag | input | 1 | Serial receive flag |
| ser_tx_flag | input | 1 | Serial transmit flag |
| pwr_flag | input | 1 | Power-fail warning flag |
| en_reg | input | 8 | Enable register contents, bit 7 global |
| pwr_en | input | 1 | Power-fail enable |
| pri_reg | input | 5 | Priority bits for the five ordinary sources |
| insn_done | input | 1 | Instruction-boundary strobe |
| reti | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | One-cycle call request |
| irq_vec | output | 16 | Vector address of the taken source |
| flag_clr | output | 6 | Flag-clear pulses by source index |

## Verification
The assertions assume that the CPU never issues `reti` while no routine is in service, and that each `reti` matches one earlier call. The bench keeps this by resetting between scenarios and pairing every return with a request it has already seen. The assertions also assume that a peripheral drops its flag within a cycle or two of its clear pulse. The stimulus lowers each taken flag before the next boundary strobe, except for serial flags that are deliberately left set. Strobes are pulses of one or two cycles, driven away from the clock edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   localparam int unsigned N_SRC   = 6;
   localparam int unsigned IDX_EX0 = 0;
   localparam int unsigned IDX_TM0 = 1;
   localparam int unsigned IDX_EX1 = 2;
   localparam int unsigned IDX_TM1 = 3;
   localparam int unsigned IDX_SER = 4;
   localparam int unsigned IDX_PWR = 5;

   typedef logic [N_SRC-1:0] src_vec_t;

   // sources that the arbiter clears itself on a call
   localparam src_vec_t AUTO_CLR = src_vec_t'(6'b10_1111);

   // address of a source's vector: evenly spaced from a base
   function automatic int unsigned vec_addr(input int unsigned base,
                                            input int unsigned stride,
                                            input int unsigned idx);
      return base + idx * stride;
   endfunction

   // fixed polling order inside one level: power-fail, then index 0 upward
   function automatic src_vec_t poll_pick(input src_vec_t req);
      src_vec_t g;
      logic     found;
      g     = '0;
      found = 1'b0;
      if (req[IDX_PWR]) begin
         g[IDX_PWR] = 1'b1;
         found      = 1'b1;
      end
      for (int i = 0; i < int'(N_SRC); i++) begin
         if (!found && i != int'(IDX_PWR) && req[i]) begin
            g[i]  = 1'b1;
            found = 1'b1;
         end
      end
      return g;
   endfunction

endpackage

// File: rtl/irqc_src_gate.sv
module irqc_src_gate
   import irqc_pkg::*;
#(
   parameter int unsigned EN_W   = 8,
   parameter int unsigned GLB_BIT = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  src_vec_t         pend,
   input  logic [EN_W-1:0]  en_reg,
   input  logic             pwr_en,
   input  logic [IDX_SER:0] pri_reg,
   output src_vec_t         req_hi,
   output src_vec_t         req_lo
);

   if (GLB_BIT >= EN_W) begin : g_bad_glb
      $error("irqc_src_gate: GLB_BIT outside enable register");
   end
   if (EN_W < IDX_SER + 2) begin : g_bad_w
      $error("irqc_src_gate: enable register too narrow");
   end

   logic glb_on;
   assign glb_on = en_reg[GLB_BIT];

   for (genvar i = 0; i < int'(N_SRC); i++) begin : g_src
      logic allowed;
      logic high;
      if (i == int'(IDX_PWR)) begin : g_pwr
         assign allowed = pwr_en;
         assign high    = 1'b1;
      end else begin : g_norm
         assign allowed = glb_on & en_reg[i];
         assign high    = pri_reg[i];
      end
      assign req_hi[i] = pend[i] & allowed & high;
      assign req_lo[i] = pend[i] & allowed & ~high;

      // R4 a source whose enable is off never shows as a request
      if (i == int'(IDX_PWR)) begin : g_chk_pwr
         a_r4_pwr_gated: assert property (@(posedge clk) disable iff (!rst_n)
            !pwr_en |-> !(req_hi[i] || req_lo[i]));
      end else begin : g_chk_norm
         a_r3_glb_gated: assert property (@(posedge clk) disable iff (!rst_n)
            !en_reg[GLB_BIT] |-> !(req_hi[i] || req_lo[i]));
      end
   end

endmodule

// File: rtl/irqc_pick.sv
module irqc_pick
   import irqc_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  src_vec_t req_hi,
   input  src_vec_t req_lo,
   input  logic     svc_hi,
   input  logic     svc_lo,
   output src_vec_t grant,
   output logic     grant_hi,
   output logic     any
);

   src_vec_t elig_hi, elig_lo;
   src_vec_t pick_hi, pick_lo;

   // R10 nesting: a high routine blocks all, a low routine blocks low
   assign elig_hi = svc_hi ? '0 : req_hi;
   assign elig_lo = (svc_hi || svc_lo) ? '0 : req_lo;

   assign pick_hi = poll_pick(elig_hi);
   assign pick_lo = poll_pick(elig_lo);

   always_comb begin
      grant_hi = |elig_hi;
      grant    = grant_hi ? pick_hi : pick_lo;
      any      = |grant;
   end

   a_r8_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   a_r9_hi_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (|elig_hi) |-> ((grant & req_lo) == '0));
   a_r8_grant_pending: assert property (@(posedge clk) disable iff (!rst_n)
      ((grant & ~(req_hi | req_lo)) == '0));

endmodule

// File: rtl/irqc_svc_state.sv
module irqc_svc_state (
   input  logic clk,
   input  logic rst_n,
   input  logic take,
   input  logic take_hi,
   input  logic reti,
   output logic svc_hi,
   output logic svc_lo
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         svc_hi <= 1'b0;
         svc_lo <= 1'b0;
      end else if (take) begin
         if (take_hi) svc_hi <= 1'b1;
         else         svc_lo <= 1'b1;
      end else if (reti) begin
         // R11 the top active level ends first
         if (svc_hi) svc_hi <= 1'b0;
         else        svc_lo <= 1'b0;
      end
   end

   a_r10_no_nest_hi: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> !svc_hi);
   a_r10_no_nest_lo: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !take_hi) |-> !svc_lo);
   a_r11_reti_top: assert property (@(posedge clk) disable iff (!rst_n)
      (reti && !take && svc_hi) |=> (!svc_hi && $stable(svc_lo)));
   a_r12_no_take_on_reti: assert property (@(posedge clk) disable iff (!rst_n)
      !(take && reti));

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
   import irqc_pkg::*;
#(
   parameter int unsigned VEC_W      = 16,
   parameter int unsigned VEC_BASE   = 3,
   parameter int unsigned VEC_STRIDE = 8,
   parameter int unsigned EN_W       = 8,
   parameter int unsigned GLB_BIT    = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       main_flag,
   input  logic             ser_rx_flag,
   input  logic             ser_tx_flag,
   input  logic             pwr_flag,
   input  logic [EN_W-1:0]  en_reg,
   input  logic             pwr_en,
   input  logic [4:0]       pri_reg,
   input  logic             insn_done,
   input  logic             reti,
   output logic             irq_req,
   output logic [VEC_W-1:0] irq_vec,
   output logic [5:0]       flag_clr
);

   localparam int unsigned TOP_ADDR = VEC_BASE + (N_SRC - 1) * VEC_STRIDE;
   localparam logic [VEC_W-1:0] PWR_VEC = VEC_W'(TOP_ADDR);

   if (TOP_ADDR >= (64'd1 << VEC_W)) begin : g_bad_vec
      $error("irq_arbiter: vector width too small for the vector table");
   end
   if (VEC_STRIDE == 0) begin : g_bad_stride
      $error("irq_arbiter: vector stride must be nonzero");
   end

   src_vec_t pend, req_hi, req_lo, grant;
   logic     grant_hi, any, take, svc_hi, svc_lo;
   logic [VEC_W-1:0] next_vec;

   // R7 receive and transmit share one source
   assign pend = {pwr_flag, ser_rx_flag | ser_tx_flag, main_flag};

   irqc_src_gate #(.EN_W(EN_W), .GLB_BIT(GLB_BIT)) u_gate (
      .clk(clk), .rst_n(rst_n), .pend(pend), .en_reg(en_reg),
      .pwr_en(pwr_en), .pri_reg(pri_reg), .req_hi(req_hi), .req_lo(req_lo)
   );

   irqc_pick u_pick (
      .clk(clk), .rst_n(rst_n), .req_hi(req_hi), .req_lo(req_lo),
      .svc_hi(svc_hi), .svc_lo(svc_lo), .grant(grant),
      .grant_hi(grant_hi), .any(any)
   );

   // R5 R12 a call is accepted only at a clean boundary
   assign take = insn_done & ~reti & ~irq_req & any;

   irqc_svc_state u_svc (
      .clk(clk), .rst_n(rst_n), .take(take), .take_hi(grant_hi),
      .reti(reti), .svc_hi(svc_hi), .svc_lo(svc_lo)
   );

   // vector encoder built from the one-hot grant
   always_comb begin
      next_vec = '0;
      for (int i = 0; i < int'(N_SRC); i++) begin
         if (grant[i]) next_vec = VEC_W'(vec_addr(VEC_BASE, VEC_STRIDE, i));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_req  <= 1'b0;
         irq_vec  <= '0;
         flag_clr <= '0;
      end else begin
         irq_req  <= take;
         flag_clr <= take ? (grant & AUTO_CLR) : '0;
         if (take) irq_vec <= next_vec;
      end
   end

   a_r5_req_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> $past(insn_done));
   a_r5_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |=> !irq_req);
   a_r6_clr_with_req: assert property (@(posedge clk) disable iff (!rst_n)
      (|flag_clr) |-> (irq_req && $onehot(flag_clr)));
   a_r6_serial_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_clr[IDX_SER]);
   a_r3_glb_needed: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && irq_vec != PWR_VEC) |-> $past(en_reg[GLB_BIT]));
   a_r12_no_take_in_req: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |=> $stable(irq_vec));

endmodule

// File: tb/tb_irq_arbiter.sv
`timescale 1ns/1ps
module tb_irq_arbiter;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  main_flag = '0;
   logic        ser_rx_flag = 1'b0, ser_tx_flag = 1'b0, pwr_flag = 1'b0;
   logic [7:0]  en_reg = '0;
   logic        pwr_en = 1'b0;
   logic [4:0]  pri_reg = '0;
   logic        insn_done = 1'b0, reti = 1'b0;
   logic        irq_req;
   logic [15:0] irq_vec;
   logic [5:0]  flag_clr;

   always #2.5 clk = ~clk;

   irq_arbiter dut (
      .clk(clk), .rst_n(rst_n), .main_flag(main_flag),
      .ser_rx_flag(ser_rx_flag), .ser_tx_flag(ser_tx_flag),
      .pwr_flag(pwr_flag), .en_reg(en_reg), .pwr_en(pwr_en),
      .pri_reg(pri_reg), .insn_done(insn_done), .reti(reti),
      .irq_req(irq_req), .irq_vec(irq_vec), .flag_clr(flag_clr)
   );

   typedef struct {
      logic [15:0] vec;
      logic [5:0]  clr;
      string       tag;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   errors = 0;
   bit   done = 0;

   task automatic expect_call(input logic [15:0] v, input logic [5:0] c,
                              input string tag);
      exp_t e;
      e.vec = v; e.clr = c; e.tag = tag;
      q.push_back(e);
   endtask

   // monitor: compares every request against the scoreboard
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (irq_req) begin
            checks++;
            if (q.size() == 0) begin
               errors++;
               $display("FAIL unexpected call: actual vec=%h clr=%b expected none",
                        irq_vec, flag_clr);
            end else begin
               exp_t e;
               e = q.pop_front();
               if (irq_vec !== e.vec || flag_clr !== e.clr) begin
                  errors++;
                  $display("FAIL %s: actual vec=%h clr=%b expected vec=%h clr=%b",
                           e.tag, irq_vec, flag_clr, e.vec, e.clr);
               end
            end
         end else if (flag_clr !== 6'b0) begin
            checks++;
            errors++;
            $display("FAIL R6 clear without call: actual clr=%b expected 000000",
                     flag_clr);
         end
      end
   end

   task automatic strobe();
      @(negedge clk) insn_done = 1'b1;
      @(negedge clk) insn_done = 1'b0;
   endtask

   task automatic do_reti();
      @(negedge clk) reti = 1'b1;
      @(negedge clk) reti = 1'b0;
   endtask

   task automatic drain(input string tag);
      @(negedge clk);
      checks++;
      if (q.size() != 0) begin
         errors++;
         $display("FAIL %s: actual %0d calls missing expected 0", tag, q.size());
         q.delete();
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      main_flag = '0; ser_rx_flag = 0; ser_tx_flag = 0; pwr_flag = 0;
      en_reg = '0; pwr_en = 0; pri_reg = '0; insn_done = 0; reti = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // take one source alone and return from it
   task automatic single(input int idx, input logic [15:0] v,
                         input logic [5:0] c, input string tag);
      do_reset();
      en_reg = 8'h9F; pwr_en = 1'b1;
      if (idx < 4) main_flag[idx] = 1'b1;
      else if (idx == 4) ser_rx_flag = 1'b1;
      else if (idx == 5) pwr_flag = 1'b1;
      else ser_tx_flag = 1'b1;
      expect_call(v, c, tag);
      strobe();
      drain(tag);
   endtask

   initial begin
      do_reset();
      // R1 reset state
      @(negedge clk);
      checks++;
      if (irq_req !== 1'b0 || flag_clr !== 6'b0) begin
         errors++;
         $display("FAIL R1: actual req=%b clr=%b expected 0 000000", irq_req, flag_clr);
      end
      strobe();
      drain("R1 no source");

      // R2 R6 R7 vectors and clear lines per source
      single(0, 16'h0003, 6'b000001, "R2 ext0");
      single(1, 16'h000B, 6'b000010, "R2 tmr0");
      single(2, 16'h0013, 6'b000100, "R2 ext1");
      single(3, 16'h001B, 6'b001000, "R2 tmr1");
      single(4, 16'h0023, 6'b000000, "R7 rx");
      single(6, 16'h0023, 6'b000000, "R7 tx");
      single(5, 16'h002B, 6'b100000, "R6 pwr");

      // R3 global enable off
      do_reset();
      en_reg = 8'h1F; pwr_en = 1'b1; main_flag = 4'b0001;
      strobe();
      drain("R3 global off");
      pwr_flag = 1'b1;
      expect_call(16'h002B, 6'b100000, "R3 pwr ignores global");
      strobe();
      drain("R3 pwr ignores global");

      // R4 individual enables off
      do_reset();
      en_reg = 8'h80 | 8'h15; main_flag = 4'b1010; ser_tx_flag = 1'b0;
      pwr_flag = 1'b1; pwr_en = 1'b0;
      strobe();
      drain("R4 disabled sources");

      // R5 no strobe, no call
      do_reset();
      en_reg = 8'h9F; main_flag = 4'b0100;
      repeat (5) @(negedge clk);
      drain("R5 no strobe");
      expect_call(16'h0013, 6'b000100, "R5 strobe");
      strobe();
      drain("R5 strobe");

      // R8 polling order at one level
      do_reset();
      en_reg = 8'h9F; pwr_en = 1'b1; pri_reg = 5'b0;
      main_flag = 4'b1111; ser_rx_flag = 1'b1; pwr_flag = 1'b1;
      pri_reg = 5'b11111;
      for (int k = 0; k < 6; k++) begin
         int idx;
         idx = (k == 0) ? 5 : k - 1;
         expect_call(16'h0003 + 16'(idx * 8),
                     (idx == 4) ? 6'b0 : (6'b1 << idx), "R8 order");
         strobe();
         drain("R8 order");
         if (idx < 4) main_flag[idx] = 1'b0;
         else if (idx == 4) ser_rx_flag = 1'b0;
         else pwr_flag = 1'b0;
         do_reti();
      end

      // R9 high level beats polling order
      do_reset();
      en_reg = 8'h9F; pri_reg = 5'b10000; main_flag = 4'b0001; ser_tx_flag = 1'b1;
      expect_call(16'h0023, 6'b0, "R9 serial high");
      strobe();
      drain("R9 serial high");

      // R10 R11 nesting and return
      do_reset();
      en_reg = 8'h9F; pri_reg = 5'b01000; main_flag = 4'b0001;
      expect_call(16'h0003, 6'b000001, "R10 low entry");
      strobe();
      drain("R10 low entry");
      main_flag = 4'b1000;
      expect_call(16'h001B, 6'b001000, "R10 preempt");
      strobe();
      drain("R10 preempt");
      main_flag = 4'b0100;
      strobe();
      drain("R10 blocked in high");
      do_reti();
      strobe();
      drain("R11 low still active");
      do_reti();
      expect_call(16'h0013, 6'b000100, "R11 after both returns");
      strobe();
      drain("R11 after both returns");

      // R6 serial flag kept, taken again after return
      do_reset();
      en_reg = 8'h9F; ser_rx_flag = 1'b1;
      expect_call(16'h0023, 6'b0, "R6 serial first");
      strobe();
      drain("R6 serial first");
      do_reti();
      expect_call(16'h0023, 6'b0, "R6 serial again");
      strobe();
      drain("R6 serial again");

      // R12 strobe during request cycle and with reti
      do_reset();
      en_reg = 8'h9F; pri_reg = 5'b01000; main_flag = 4'b0001;
      expect_call(16'h0003, 6'b000001, "R12 first");
      @(negedge clk) insn_done = 1'b1;
      @(negedge clk) main_flag = 4'b1000;
      @(negedge clk) insn_done = 1'b0;
      drain("R12 strobe in request cycle");
      expect_call(16'h001B, 6'b001000, "R12 later");
      strobe();
      drain("R12 later");
      main_flag = 4'b0010; pri_reg = 5'b0;
      @(negedge clk) begin reti = 1'b1; insn_done = 1'b1; end
      @(negedge clk) begin reti = 1'b0; insn_done = 1'b0; end
      drain("R12 strobe with reti");
      do_reti();
      expect_call(16'h000B, 6'b000010, "R12 after returns");
      strobe();
      drain("R12 after returns");

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule